// File: doc/BRIEF.md
# Idle-Timeout Power-Down Controller with Epoch Slack Guard

This block conserves energy in a memory made of several independently controllable devices. Each device has a power state, 0 being active and higher numbers being deeper low-power states. It also has an idle counter. A device that sits unused longer than the programmable break-even time of its current state is stepped one state deeper. An access to a device in a low-power state brings it back to active, but only when the resulting total power, summed from programmable per-state power figures, stays within a programmable budget. A denied device stays where it is, and the budget-limiting logic outside this block deals with the access.

Power-down costs performance, because accesses have to wait for devices to wake. A slack counter bounds that cost. Over each fixed epoch the counter earns a programmable fraction of every elapsed cycle and loses one for every cycle an access waits for a wake-up. Once the slack goes negative, idle demotion is switched off until the epoch ends. At the next epoch boundary the slack restarts at zero and demotion is allowed again.

Top module: `pd_ec_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every device state reads 0 (active) and `ec_en_o` reads 1.
- R2: The idle count of a device is the number of clock edges since its last access, its last state change or reset. While `ec_en_o` is 1, a device that is not accessed and whose idle count is above the threshold of its current state moves to state+1 on that edge, and its idle count restarts. The threshold for state s is field s (bits s*IDLE_W upward) of `cfg_thr_i`.
- R3: An access to a device clears its idle count, so a device accessed at intervals no longer than its threshold never leaves its state.
- R4: A device in the deepest state (N_ST-1) stays there while unaccessed.
- R5: An access to a device in a nonzero state returns it to state 0 on that edge only if T - P(cur) + P(0) <= `cfg_budget_i`. T is the sum of P(state) over all devices and P(s) is field s (bits s*PWR_W upward) of `cfg_pwr_i`. Otherwise the device's state is unchanged.
- R6: At most one device wakes per cycle. Only the lowest-index device that requests a wake is considered, and other requesters wait for a later cycle.
- R7: The slack starts at 0 in each epoch. Each cycle an accumulator of FRAC_W bits adds `cfg_frac_i`, and its carry adds 1 to the slack. A cycle with `wake_wait_i` high subtracts 1.
- R8: `ec_en_o` drops on the edge where the slack becomes negative and stays low for the rest of the epoch. While it is low no device is demoted, and wakes still happen.
- R9: Every EPOCH_CYC cycles a boundary cycle clears the slack and the accumulator and sets `ec_en_o` to 1. `wake_wait_i` is not debited in that cycle. The first boundary edge is the EPOCH_CYC-th edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_i | input | N_DEV | Per-device access strobe |
| wake_wait_i | input | 1 | An access is stalled waiting for a wake-up this cycle |
| cfg_thr_i | input | (N_ST-1)*IDLE_W | Break-even idle threshold per non-deepest state |
| cfg_pwr_i | input | N_ST*PWR_W | Power figure per state |
| cfg_budget_i | input | PWR_W+clog2(N_DEV+1) | Power budget for wake decisions |
| cfg_frac_i | input | FRAC_W | Allowed slowdown as a fraction of 2^FRAC_W |
| dev_state_o | output | N_DEV*clog2(N_ST) | Commanded power state per device |
| ec_en_o | output | 1 | Idle demotion currently enabled |

## Verification
The timeout path is driven three ways. An untouched device shows the exact edge of each step. A device accessed at intervals shorter than its threshold stays in its state. A device that has reached the deepest state stays there. The wake path is driven with two simultaneous requesters under a generous budget, which separates the lowest-index priority from budget denial, and then with a budget one step below and then exactly at the needed power, which pins down the inclusive comparison. For the slack, constant stall cycles at a small fraction show the prompt drop and that no demotion happens until the epoch ends. A half-cycle fraction with stalls timed against the carries shows credit and debit cancelling exactly. Constrained-random access, stall and budget traffic is checked against a cycle model on top of these cases.

// File: rtl/pd_ec_pkg.sv
package pd_ec_pkg;
   // Bits needed to encode n distinct values (at least one).
   function automatic int unsigned enc_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pd_idle_lane.sv
module pd_idle_lane #(
   parameter int unsigned SW     = 2,
   parameter int unsigned IDLE_W = 16,
   parameter int unsigned DEEP   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access_i,
   input  logic              ec_en_i,
   input  logic [IDLE_W-1:0] thr_i,
   input  logic              wake_i,
   output logic [SW-1:0]     state_o
);
   localparam logic [SW-1:0]     DEEP_ST  = SW'(DEEP);
   localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

   logic [IDLE_W-1:0] idle_q;
   logic [SW-1:0]     st_q;
   logic              demote;

   always_comb begin
      demote = ec_en_i && !access_i && (st_q != DEEP_ST) && (idle_q > thr_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         idle_q <= '0;
      end else begin
         if (wake_i)      st_q <= '0;
         else if (demote) st_q <= st_q + 1'b1;

         if (access_i || demote)   idle_q <= '0;
         else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/pd_wake_gate.sv
module pd_wake_gate #(
   parameter int unsigned N_DEV = 8,
   parameter int unsigned N_ST  = 4,
   parameter int unsigned SW    = 2,
   parameter int unsigned PWR_W = 10,
   parameter int unsigned TOT_W = 14
) (
   input  logic [N_DEV*SW-1:0]   state_i,
   input  logic [N_DEV-1:0]      access_i,
   input  logic [N_ST*PWR_W-1:0] pwr_i,
   input  logic [TOT_W-1:0]      budget_i,
   output logic [N_DEV-1:0]      wake_o
);
   localparam int unsigned N_ENC = 1 << SW;

   logic [PWR_W-1:0] pw [N_ENC];

   for (genvar s = 0; s < N_ENC; s++) begin : g_pw
      if (s < N_ST) begin : g_used
         assign pw[s] = pwr_i[s*PWR_W +: PWR_W];
      end else begin : g_spare
         assign pw[s] = '0;
      end
   end

   logic [TOT_W-1:0] total;
   logic [N_DEV-1:0] pick;
   logic [SW-1:0]    pick_st;
   logic             found;
   logic [TOT_W:0]   need;

   always_comb begin
      total   = '0;
      pick    = '0;
      pick_st = '0;
      found   = 1'b0;
      for (int d = 0; d < int'(N_DEV); d++) begin
         total = total + TOT_W'(pw[state_i[d*SW +: SW]]);
         if (!found && access_i[d] && (state_i[d*SW +: SW] != '0)) begin
            found   = 1'b1;
            pick[d] = 1'b1;
            pick_st = state_i[d*SW +: SW];
         end
      end
      need   = {1'b0, total} - (TOT_W+1)'(pw[pick_st]) + (TOT_W+1)'(pw[0]);
      wake_o = (found && (need <= {1'b0, budget_i})) ? pick : '0;
   end
endmodule

// File: rtl/pd_slack_guard.sv
module pd_slack_guard #(
   parameter int unsigned EPOCH_CYC = 5000000,
   parameter int unsigned FRAC_W    = 10,
   parameter int unsigned EP_W      = 23,
   parameter int unsigned SLK_W     = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic              wait_i,
   output logic              ec_en_o,
   output logic              wrap_o
);
   localparam logic [EP_W-1:0] EP_LAST = EP_W'(EPOCH_CYC - 1);

   logic [EP_W-1:0]          ep_q;
   logic [FRAC_W-1:0]        acc_q;
   logic signed [SLK_W-1:0]  slack_q;
   logic signed [SLK_W-1:0]  slack_nxt;
   logic [FRAC_W:0]          sum;
   logic                     ec_q;

   always_comb begin
      wrap_o    = (ep_q == EP_LAST);
      sum       = {1'b0, acc_q} + {1'b0, frac_i};
      slack_nxt = slack_q + SLK_W'(sum[FRAC_W]) - SLK_W'(wait_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_q    <= '0;
         acc_q   <= '0;
         slack_q <= '0;
         ec_q    <= 1'b1;
      end else if (wrap_o) begin
         ep_q    <= '0;
         acc_q   <= '0;
         slack_q <= '0;
         ec_q    <= 1'b1;
      end else begin
         ep_q    <= ep_q + 1'b1;
         acc_q   <= sum[FRAC_W-1:0];
         slack_q <= slack_nxt;
         if (slack_nxt[SLK_W-1]) ec_q <= 1'b0;
      end
   end

   assign ec_en_o = ec_q;
endmodule

// File: rtl/pd_ec_ctrl.sv
module pd_ec_ctrl #(
   parameter int unsigned N_DEV     = 8,
   parameter int unsigned N_ST      = 4,
   parameter int unsigned IDLE_W    = 16,
   parameter int unsigned PWR_W     = 10,
   parameter int unsigned FRAC_W    = 10,
   parameter int unsigned EPOCH_CYC = 5000000,
   localparam int unsigned SW       = pd_ec_pkg::enc_bits(N_ST),
   localparam int unsigned TOT_W    = PWR_W + pd_ec_pkg::enc_bits(N_DEV + 1),
   localparam int unsigned EP_W     = pd_ec_pkg::enc_bits(EPOCH_CYC),
   localparam int unsigned SLK_W    = EP_W + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_DEV-1:0]           access_i,
   input  logic                       wake_wait_i,
   input  logic [(N_ST-1)*IDLE_W-1:0] cfg_thr_i,
   input  logic [N_ST*PWR_W-1:0]      cfg_pwr_i,
   input  logic [TOT_W-1:0]           cfg_budget_i,
   input  logic [FRAC_W-1:0]          cfg_frac_i,
   output logic [N_DEV*SW-1:0]        dev_state_o,
   output logic                       ec_en_o
);
   localparam int unsigned N_ENC = 1 << SW;

   // Elaboration-time parameter checks
   if (N_ST < 2) begin : g_bad_nst
      $error("pd_ec_ctrl: N_ST must be at least 2");
   end
   if (N_DEV < 1) begin : g_bad_ndev
      $error("pd_ec_ctrl: N_DEV must be at least 1");
   end
   if (EPOCH_CYC < 2) begin : g_bad_epoch
      $error("pd_ec_ctrl: EPOCH_CYC must be at least 2");
   end
   if (FRAC_W < 1 || IDLE_W < 1 || PWR_W < 1) begin : g_bad_width
      $error("pd_ec_ctrl: field widths must be nonzero");
   end

   logic [IDLE_W-1:0] thr_a [N_ENC];
   logic [N_DEV-1:0]  wake;
   logic              ec_en;
   logic              ep_wrap;

   for (genvar s = 0; s < N_ENC; s++) begin : g_thr
      if (s < N_ST - 1) begin : g_prog
         assign thr_a[s] = cfg_thr_i[s*IDLE_W +: IDLE_W];
      end else begin : g_none
         assign thr_a[s] = '1;
      end
   end

   for (genvar d = 0; d < N_DEV; d++) begin : g_lane
      logic [SW-1:0] st;
      pd_idle_lane #(
         .SW     (SW),
         .IDLE_W (IDLE_W),
         .DEEP   (N_ST - 1)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .access_i (access_i[d]),
         .ec_en_i  (ec_en),
         .thr_i    (thr_a[st]),
         .wake_i   (wake[d]),
         .state_o  (st)
      );
      assign dev_state_o[d*SW +: SW] = st;
   end

   pd_wake_gate #(
      .N_DEV (N_DEV),
      .N_ST  (N_ST),
      .SW    (SW),
      .PWR_W (PWR_W),
      .TOT_W (TOT_W)
   ) u_gate (
      .state_i  (dev_state_o),
      .access_i (access_i),
      .pwr_i    (cfg_pwr_i),
      .budget_i (cfg_budget_i),
      .wake_o   (wake)
   );

   pd_slack_guard #(
      .EPOCH_CYC (EPOCH_CYC),
      .FRAC_W    (FRAC_W),
      .EP_W      (EP_W),
      .SLK_W     (SLK_W)
   ) u_slack (
      .clk     (clk),
      .rst_n   (rst_n),
      .frac_i  (cfg_frac_i),
      .wait_i  (wake_wait_i),
      .ec_en_o (ec_en),
      .wrap_o  (ep_wrap)
   );

   assign ec_en_o = ec_en;
endmodule

// File: rtl/pd_ec_ctrl_chk.sv
module pd_ec_ctrl_chk #(
   parameter int unsigned N_DEV = 8,
   parameter int unsigned SW    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_DEV-1:0]    access_i,
   input logic [N_DEV*SW-1:0] dev_state_o,
   input logic                ec_en_o,
   input logic                epoch_wrap
);
   logic [N_DEV*SW-1:0] prev_st;
   logic [N_DEV-1:0]    prev_acc;
   logic                prev_ec;
   logic                prev_wrap;
   logic [N_DEV-1:0]    woke;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_st   <= '0;
         prev_acc  <= '0;
         prev_ec   <= 1'b1;
         prev_wrap <= 1'b0;
      end else begin
         prev_st   <= dev_state_o;
         prev_acc  <= access_i;
         prev_ec   <= ec_en_o;
         prev_wrap <= epoch_wrap;
      end
   end

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      logic [SW-1:0] cur;
      logic [SW-1:0] old;
      assign cur     = dev_state_o[d*SW +: SW];
      assign old     = prev_st[d*SW +: SW];
      assign woke[d] = (cur == '0) && (old != '0);

      // R2
      single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cur > old) |-> (cur == old + 1'b1));

      // R8
      demote_needs_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cur > old) |-> prev_ec);

      // R5
      wake_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
         woke[d] |-> prev_acc[d]);
   end

   // R6
   one_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(woke) <= 1);

   // R9
   reenable_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ec_en_o && !prev_ec) |-> prev_wrap);
endmodule

bind pd_ec_ctrl pd_ec_ctrl_chk #(
   .N_DEV (N_DEV),
   .SW    (SW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .access_i    (access_i),
   .dev_state_o (dev_state_o),
   .ec_en_o     (ec_en_o),
   .epoch_wrap  (ep_wrap)
);

// File: tb/sim_pd_ec_ctrl.sv
`timescale 1ns/1ps
module sim_pd_ec_ctrl;
   localparam int N_DEV  = 4;
   localparam int N_ST   = 3;
   localparam int IDLE_W = 8;
   localparam int PWR_W  = 8;
   localparam int FRAC_W = 8;
   localparam int EPOCH  = 400;
   localparam int SW     = 2;
   localparam int TOT_W  = PWR_W + 3;

   logic                       clk = 1'b0;
   logic                       rst_n = 1'b0;
   logic [N_DEV-1:0]           acc = '0;
   logic                       wwait = 1'b0;
   logic [(N_ST-1)*IDLE_W-1:0] cfg_thr = {8'd10, 8'd5};
   logic [N_ST*PWR_W-1:0]      cfg_pwr = {8'd2, 8'd8, 8'd20};
   logic [TOT_W-1:0]           cfg_budget = 11'd1000;
   logic [FRAC_W-1:0]          cfg_frac = 8'd8;
   logic [N_DEV*SW-1:0]        dev_state;
   logic                       ec_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   pd_ec_ctrl #(
      .N_DEV(N_DEV), .N_ST(N_ST), .IDLE_W(IDLE_W), .PWR_W(PWR_W),
      .FRAC_W(FRAC_W), .EPOCH_CYC(EPOCH)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .access_i(acc), .wake_wait_i(wwait),
      .cfg_thr_i(cfg_thr), .cfg_pwr_i(cfg_pwr), .cfg_budget_i(cfg_budget),
      .cfg_frac_i(cfg_frac), .dev_state_o(dev_state), .ec_en_o(ec_en)
   );

   // ---------------- reference model ----------------
   int m_st [N_DEV];
   int m_idle [N_DEV];
   int m_slack, m_facc, m_ep;
   int m_ec;

   function automatic int pw_of(int s);
      return int'((cfg_pwr >> (s*PWR_W)) & 8'hFF);
   endfunction

   function automatic int thr_of(int s);
      return int'((cfg_thr >> (s*IDLE_W)) & 8'hFF);
   endfunction

   function automatic int dut_st(int d);
      return int'((dev_state >> (d*SW)) & 2'b11);
   endfunction

   task automatic model_reset();
      for (int d = 0; d < N_DEV; d++) begin m_st[d] = 0; m_idle[d] = 0; end
      m_slack = 0; m_facc = 0; m_ep = 0; m_ec = 1;
   endtask

   task automatic model_step();
      int tot, wk, sum, nst, dem;
      tot = 0; wk = -1;
      for (int d = 0; d < N_DEV; d++) begin
         tot += pw_of(m_st[d]);
         if (wk < 0 && acc[d] && m_st[d] != 0) wk = d;
      end
      if (wk >= 0 && (tot - pw_of(m_st[wk]) + pw_of(0)) > int'(cfg_budget)) wk = -1;
      for (int d = 0; d < N_DEV; d++) begin
         dem = (m_ec != 0 && !acc[d] && m_st[d] != N_ST-1 && m_idle[d] > thr_of(m_st[d])) ? 1 : 0;
         nst = (d == wk) ? 0 : (dem != 0 ? m_st[d] + 1 : m_st[d]);
         if (acc[d] || dem != 0) m_idle[d] = 0;
         else if (m_idle[d] != 255) m_idle[d] = m_idle[d] + 1;
         m_st[d] = nst;
      end
      if (m_ep == EPOCH-1) begin
         m_ep = 0; m_slack = 0; m_facc = 0; m_ec = 1;
      end else begin
         m_ep = m_ep + 1;
         sum = m_facc + int'(cfg_frac);
         m_facc = sum & 255;
         m_slack = m_slack + (sum >> FRAC_W) - int'(wwait);
         if (m_slack < 0) m_ec = 0;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   // ---------------- checking ----------------
   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int d = 0; d < N_DEV; d++) chk(cur_tag, dut_st(d), m_st[d]);
         chk(cur_tag, int'(ec_en), m_ec);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #4000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   int cyc = 0;
   task automatic step1();
      @(negedge clk);
      cyc++;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int d = 0; d < N_DEV; d++) chk("R1", dut_st(d), 0);
      chk("R1", int'(ec_en), 1);
      rst_n = 1'b1;

      // R2 / R3 / R4 directed: dev1 accessed every 4th edge, others idle
      cur_tag = "R2";
      for (int i = 1; i <= 40; i++) begin
         acc = (i % 4 == 1) ? 4'b0010 : 4'b0000;
         step1();
         if (i == 6)  chk("R2", dut_st(0), 0);
         if (i == 7)  chk("R2", dut_st(0), 1);
         if (i == 18) chk("R2", dut_st(0), 1);
         if (i == 19) chk("R2", dut_st(0), 2);
         if (i == 40) begin
            chk("R3", dut_st(1), 0);
            chk("R4", dut_st(0), 2);
            chk("R4", dut_st(3), 2);
         end
      end

      // R5 / R6: two simultaneous requesters, then budget boundary
      cur_tag = "R6";
      acc = 4'b0111; step1();
      chk("R6", dut_st(0), 0);
      chk("R6", dut_st(2), 2);
      step1();
      chk("R5", dut_st(2), 0);
      cur_tag = "R5";
      cfg_budget = 11'd79; acc = 4'b1111;
      step1(); step1();
      chk("R5", dut_st(3), 2);
      cfg_budget = 11'd80; step1();
      chk("R5", dut_st(3), 0);
      acc = 4'b0000; cfg_budget = 11'd1000;

      // R8: stalls right after the first epoch boundary
      cur_tag = "R8";
      while (cyc < 410) step1();
      wwait = 1'b1;
      step1(); step1();
      chk("R8", int'(ec_en), 0);
      repeat (18) step1();
      wwait = 1'b0;
      acc = 4'b1111;
      repeat (4) step1();
      acc = 4'b0000;
      repeat (40) step1();
      for (int d = 0; d < N_DEV; d++) chk("R8", dut_st(d), 0);
      chk("R8", int'(ec_en), 0);

      // R9: re-enable at the second boundary (edge 800)
      cur_tag = "R9";
      while (cyc < 799) step1();
      chk("R9", int'(ec_en), 0);
      cfg_frac = 8'd128;
      step1();
      chk("R9", int'(ec_en), 1);

      // R7: half-cycle credit against stalls
      cur_tag = "R7";
      step1(); step1();          // edges 801, 802: slack reaches 1
      wwait = 1'b1;
      step1(); step1();          // edges 803, 804: slack 0, 0
      chk("R7", int'(ec_en), 1);
      step1();                   // edge 805: slack -1
      chk("R7", int'(ec_en), 0);
      wwait = 1'b0;

      // Constrained random traffic against the model
      cur_tag = "R6";
      for (int i = 0; i < 3000; i++) begin
         for (int d = 0; d < N_DEV; d++) acc[d] = ($urandom % 8) == 0;
         wwait = ($urandom % 16) == 0;
         if (i % 100 == 0) begin
            cfg_budget = 11'(40 + $urandom % 50);
            cfg_frac   = 8'($urandom % 64);
         end
         step1();
      end
      acc = '0; wwait = 1'b0;
      step1();
      finish_run();
   end
endmodule